// File: doc/BRIEF.md
# UART Host Register Bank

This block is the host-side register file of a 16550-compatible serial controller. A processor reaches it through a three-bit address with separate read and write strobes. Writes land in the control registers (interrupt enables, FIFO control, line control, modem control, scratch and the 16-bit baud divisor). Reads return those registers or status words that the rest of the controller supplies: received byte, interrupt identity, line status and modem status. The serializer, the FIFOs and the baud timing are outside this block.

Addresses 0 and 1 are shared. When the divisor-access bit (bit 7 of the line control register) is clear, address 0 is the data port and address 1 is the interrupt enable register. When that bit is set, addresses 0 and 1 are the low and high divisor bytes. Address 2 is also split: a read returns interrupt identity and a write goes to FIFO control.

The byte streams at the edge are plain strobes with no back-pressure. `tx_push` acts as a valid with an implied ready that is always high, so software must check line status before it writes. `rx_pop` tells the receive side that the byte on `rx_data` was consumed in that cycle. All strobes are combinational in the access cycle. Stored fields change at the clock edge that ends a write.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the divisor, line control, interrupt enable, modem control, FIFO enable, DMA select and RX trigger outputs are all zero, and the scratch register reads 0xFF.
- R2: With divisor access clear, a read of address 0 returns `rx_data` and raises `rx_pop` in that cycle. A write to address 0 raises `tx_push` in that cycle with `tx_data` equal to the written byte.
- R3: With divisor access clear, a write to address 1 stores bits 3:0 as the interrupt enables. A read of address 1 returns those four bits with bits 7:4 as zero.
- R4: With divisor access set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. No push or pop strobe is raised, and the interrupt enables are left unchanged.
- R5: A write to address 2 stores bit 0 as FIFO enable, bit 3 as DMA select and bits 7:6 as the RX trigger level. Bit 1 raises `rx_flush` and bit 2 raises `tx_flush` for that write cycle only. Neither flush bit is stored.
- R6: A read of address 2 returns {fifo_en, fifo_en, 2'b00, int_id[2:0], ~int_pending}. The value is 0x01 when the FIFOs are disabled and nothing is pending.
- R7: Address 3 is the line control register. It is read/write on all eight bits and drives `lcr_q`. Bits 1:0 set the word length, bit 2 the stop bits, bit 3 parity enable, bit 4 even parity, bit 5 stick parity, bit 6 break, and bit 7 divisor access.
- R8: Address 4 stores bits 4:0 as modem control. It reads back with bits 7:5 as zero.
- R9: Reads of addresses 5 and 6 return `lsr_in` and `msr_in`. Writes to them change no stored field and raise no strobe.
- R10: Address 7 is a read/write scratch byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data (combinational) |
| tx_push | output | 1 | Transmit byte valid (no back-pressure) |
| tx_data | output | 8 | Transmit byte |
| rx_pop | output | 1 | Receive byte consumed |
| rx_data | input | 8 | Byte at the head of the receive side |
| int_id | input | 3 | Identity of the highest pending interrupt |
| int_pending | input | 1 | An interrupt is pending |
| lsr_in | input | 8 | Line status word |
| msr_in | input | 8 | Modem status word |
| divisor | output | 16 | Baud divisor |
| lcr_q | output | 8 | Line control register |
| ier_q | output | 4 | Interrupt enables |
| mcr_q | output | 5 | Modem control bits |
| fifo_en | output | 1 | FIFO enable |
| dma_mode | output | 1 | DMA mode select |
| rx_trig | output | 2 | RX trigger level code |
| rx_flush | output | 1 | RX FIFO reset pulse |
| tx_flush | output | 1 | TX FIFO reset pulse |

## Verification
The assertions assume the host never raises `wr_en` and `rd_en` in the same cycle. A combined access would let a read of address 0 coincide with a divisor write and blur which register the read targets. The stimulus issues each access in its own cycle and clears both strobes between accesses. Status inputs such as `rx_data`, `lsr_in`, `int_id` and `int_pending` are only changed while the strobes are low, so every read sees a value that is stable through its cycle.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int IER_W  = 4;
  localparam int MCR_W  = 5;
  localparam int NDIV   = 2;
  localparam int DIV_W  = NDIV * DW;
  localparam int DLAB_B = DW - 1;
  localparam logic [DW-1:0] SCR_RST = 8'hFF;

  typedef enum logic [AW-1:0] {
    A_DATA = 3'd0,
    A_IER  = 3'd1,
    A_IIR  = 3'd2,
    A_LCR  = 3'd3,
    A_MCR  = 3'd4,
    A_LSR  = 3'd5,
    A_MSR  = 3'd6,
    A_SCR  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic            thr;
    logic            ier;
    logic            fcr;
    logic            lcr;
    logic            mcr;
    logic            scr;
    logic [NDIV-1:0] div;
  } wr_strb_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          dlab,
  output wr_strb_t      strb,
  output logic          rx_pop
);
  always_comb begin
    strb = '0;
    case (reg_addr_e'(addr))
      A_DATA: if (dlab) strb.div[0] = wr_en; else strb.thr = wr_en;
      A_IER:  if (dlab) strb.div[1] = wr_en; else strb.ier = wr_en;
      A_IIR:  strb.fcr = wr_en;
      A_LCR:  strb.lcr = wr_en;
      A_MCR:  strb.mcr = wr_en;
      A_SCR:  strb.scr = wr_en;
      default: ;
    endcase
  end

  assign rx_pop = rd_en && (reg_addr_e'(addr) == A_DATA) && !dlab;
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strb_t         strb,
  input  logic [DW-1:0]    wr_data,
  output logic [DIV_W-1:0] divisor,
  output logic [DW-1:0]    lcr_q,
  output logic [IER_W-1:0] ier_q,
  output logic [MCR_W-1:0] mcr_q,
  output logic [DW-1:0]    scr_q,
  output logic             fifo_en,
  output logic             dma_mode,
  output logic [1:0]       rx_trig
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor <= '0;
    end else begin
      for (int b = 0; b < NDIV; b++) begin
        if (strb.div[b]) divisor[b*DW +: DW] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q    <= '0;
      ier_q    <= '0;
      mcr_q    <= '0;
      scr_q    <= SCR_RST;
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_trig  <= '0;
    end else begin
      if (strb.lcr) lcr_q <= wr_data;
      if (strb.ier) ier_q <= wr_data[IER_W-1:0];
      if (strb.mcr) mcr_q <= wr_data[MCR_W-1:0];
      if (strb.scr) scr_q <= wr_data;
      if (strb.fcr) begin
        fifo_en  <= wr_data[0];
        dma_mode <= wr_data[3];
        rx_trig  <= wr_data[DW-1:DW-2];
      end
    end
  end
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
(
  input  logic [AW-1:0]    addr,
  input  logic             dlab,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DW-1:0]    lcr_q,
  input  logic [IER_W-1:0] ier_q,
  input  logic [MCR_W-1:0] mcr_q,
  input  logic [DW-1:0]    scr_q,
  input  logic             fifo_en,
  input  logic [DW-1:0]    rx_data,
  input  logic [2:0]       int_id,
  input  logic             int_pending,
  input  logic [DW-1:0]    lsr_in,
  input  logic [DW-1:0]    msr_in,
  output logic [DW-1:0]    rd_data
);
  always_comb begin
    case (reg_addr_e'(addr))
      A_DATA: rd_data = dlab ? divisor[DW-1:0] : rx_data;
      A_IER:  rd_data = dlab ? divisor[DIV_W-1:DW]
                             : {{(DW-IER_W){1'b0}}, ier_q};
      A_IIR:  rd_data = {fifo_en, fifo_en, 2'b00, int_id, ~int_pending};
      A_LCR:  rd_data = lcr_q;
      A_MCR:  rd_data = {{(DW-MCR_W){1'b0}}, mcr_q};
      A_LSR:  rd_data = lsr_in;
      A_MSR:  rd_data = msr_in;
      default: rd_data = scr_q;
    endcase
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             tx_push,
  output logic [DW-1:0]    tx_data,
  output logic             rx_pop,
  input  logic [DW-1:0]    rx_data,
  input  logic [2:0]       int_id,
  input  logic             int_pending,
  input  logic [DW-1:0]    lsr_in,
  input  logic [DW-1:0]    msr_in,
  output logic [DIV_W-1:0] divisor,
  output logic [DW-1:0]    lcr_q,
  output logic [IER_W-1:0] ier_q,
  output logic [MCR_W-1:0] mcr_q,
  output logic             fifo_en,
  output logic             dma_mode,
  output logic [1:0]       rx_trig,
  output logic             rx_flush,
  output logic             tx_flush
);
  wr_strb_t      strb;
  logic [DW-1:0] scr_q;
  logic          dlab;

  assign dlab = lcr_q[DLAB_B];

  uart_rb_decode u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .dlab(dlab),
    .strb(strb), .rx_pop(rx_pop)
  );

  uart_rb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wr_data(wr_data),
    .divisor(divisor), .lcr_q(lcr_q), .ier_q(ier_q), .mcr_q(mcr_q),
    .scr_q(scr_q), .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_trig(rx_trig)
  );

  uart_rb_rdmux u_rd (
    .addr(addr), .dlab(dlab), .divisor(divisor), .lcr_q(lcr_q),
    .ier_q(ier_q), .mcr_q(mcr_q), .scr_q(scr_q), .fifo_en(fifo_en),
    .rx_data(rx_data), .int_id(int_id), .int_pending(int_pending),
    .lsr_in(lsr_in), .msr_in(msr_in), .rd_data(rd_data)
  );

  assign tx_push  = strb.thr;
  assign tx_data  = wr_data;
  assign rx_flush = strb.fcr && wr_data[1];
  assign tx_flush = strb.fcr && wr_data[2];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        tx_push,
  input logic        rx_pop,
  input logic [7:0]  rx_data,
  input logic        int_pending,
  input logic [15:0] divisor,
  input logic [7:0]  lcr_q,
  input logic [3:0]  ier_q,
  input logic [4:0]  mcr_q,
  input logic        fifo_en,
  input logic        rx_flush,
  input logic        tx_flush
);
  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (divisor == 16'h0 && lcr_q == 8'h0 && ier_q == 4'h0 && mcr_q == 5'h0));

  // R2
  rx_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rd_data == rx_data);

  // R3
  ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !lcr_q[7]) |=> ier_q == $past(wr_data[3:0]));

  // R4
  div_lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && lcr_q[7]) |=> divisor[7:0] == $past(wr_data));

  // R4
  dlab_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_q[7] |-> (!tx_push && !rx_pop));

  // R5
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (!rx_flush && !tx_flush && !tx_push));

  // R6
  isr_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2) |-> (rd_data[0] == !int_pending && rd_data[7:6] == {2{fifo_en}}));

  // R7
  lcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> lcr_q == $past(wr_data));

  // R9
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd5 || addr == 3'd6)) |=>
      ($stable(divisor) && $stable(lcr_q) && $stable(ier_q) && $stable(mcr_q)));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tx_push(tx_push), .rx_pop(rx_pop), .rx_data(rx_data),
  .int_pending(int_pending), .divisor(divisor), .lcr_q(lcr_q), .ier_q(ier_q),
  .mcr_q(mcr_q), .fifo_en(fifo_en), .rx_flush(rx_flush), .tx_flush(tx_flush)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        tx_push;
  logic [7:0]  tx_data;
  logic        rx_pop;
  logic [7:0]  rx_data = 8'h00;
  logic [2:0]  int_id = 3'd0;
  logic        int_pending = 1'b0;
  logic [7:0]  lsr_in = 8'h60;
  logic [7:0]  msr_in = 8'h00;
  logic [15:0] divisor;
  logic [7:0]  lcr_q;
  logic [3:0]  ier_q;
  logic [4:0]  mcr_q;
  logic        fifo_en, dma_mode, rx_flush, tx_flush;
  logic [1:0]  rx_trig;

  always #10 clk = ~clk;

  uart_regbank u0 (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_div;
  logic [7:0]  m_lcr, m_scr;
  logic [3:0]  m_ier;
  logic [4:0]  m_mcr;
  logic        m_fen, m_dma;
  logic [1:0]  m_trig;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_div = '0; m_lcr = '0; m_scr = 8'hFF; m_ier = '0; m_mcr = '0;
    m_fen = 0; m_dma = 0; m_trig = '0;
  endtask

  task automatic cmp_state(input string req);
    chk(req, "divisor", divisor, m_div);
    chk(req, "lcr_q", lcr_q, m_lcr);
    chk(req, "ier_q", ier_q, m_ier);
    chk(req, "mcr_q", mcr_q, m_mcr);
    chk(req, "fifo_en", fifo_en, m_fen);
    chk(req, "dma_mode", dma_mode, m_dma);
    chk(req, "rx_trig", rx_trig, m_trig);
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic dl = m_lcr[7];
    case (a)
      3'd0: return dl ? m_div[7:0] : rx_data;
      3'd1: return dl ? m_div[15:8] : {4'b0, m_ier};
      3'd2: return {m_fen, m_fen, 2'b00, int_id, !int_pending};
      3'd3: return m_lcr;
      3'd4: return {3'b0, m_mcr};
      3'd5: return lsr_in;
      3'd6: return msr_in;
      default: return m_scr;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return m_lcr[7] ? "R4" : (a == 0 ? "R2" : "R3");
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5, 3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // one access per cycle, entered and left at a falling edge
  task automatic cycle(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d,
                       input string req);
    logic dl;
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    #2;
    dl = m_lcr[7];
    chk(dl ? "R4" : "R2", "tx_push", tx_push, (w && a == 3'd0 && !dl));
    chk(dl ? "R4" : "R2", "rx_pop", rx_pop, (r && a == 3'd0 && !dl));
    if (tx_push) chk("R2", "tx_data", tx_data, d);
    chk("R5", "rx_flush", rx_flush, (w && a == 3'd2 && d[1]));
    chk("R5", "tx_flush", tx_flush, (w && a == 3'd2 && d[2]));
    if (r) chk(rtag(a), "rd_data", rd_data, exp_rd(a));
    @(posedge clk);
    if (w) begin
      case (a)
        3'd0: if (dl) m_div[7:0] = d;
        3'd1: if (dl) m_div[15:8] = d; else m_ier = d[3:0];
        3'd2: begin m_fen = d[0]; m_dma = d[3]; m_trig = d[7:6]; end
        3'd3: m_lcr = d;
        3'd4: m_mcr = d[4:0];
        3'd7: m_scr = d;
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    cmp_state(req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
    cycle(1, 0, a, d, req);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cycle(0, 1, a, 8'h00, req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cmp_state("R1");
    rst_n = 1;
    @(negedge clk);
    cmp_state("R1");
    rd(3'd7, "R1");                   // scratch resets to 0xFF
    rd(3'd2, "R6");                   // 0x01 at reset
    wr(3'd1, 8'hFF, "R3");
    rd(3'd1, "R3");
    wr(3'd0, 8'h5A, "R2");
    rx_data = 8'hC3;
    rd(3'd0, "R2");
    wr(3'd3, 8'h80, "R7");            // divisor access on
    wr(3'd0, 8'h34, "R4");
    wr(3'd1, 8'h12, "R4");            // ier must stay 0xF
    rd(3'd0, "R4");
    rd(3'd1, "R4");
    wr(3'd3, 8'h1B, "R7");
    rd(3'd3, "R7");
    rd(3'd1, "R3");
    wr(3'd2, 8'hC7, "R5");
    wr(3'd2, 8'h08, "R5");
    wr(3'd2, 8'h41, "R5");
    int_pending = 1; int_id = 3'b110;
    rd(3'd2, "R6");
    wr(3'd4, 8'hFF, "R8");
    rd(3'd4, "R8");
    lsr_in = 8'h21; msr_in = 8'hB4;
    wr(3'd5, 8'hAA, "R9");
    wr(3'd6, 8'h55, "R9");
    rd(3'd5, "R9");
    rd(3'd6, "R9");
    wr(3'd7, 8'hA5, "R10");
    rd(3'd7, "R10");
    for (int i = 0; i < 200; i++) begin
      logic [7:0] v = 8'((i * 37 + 11) ^ (i >> 2));
      rx_data = v ^ 8'h3C; lsr_in = v + 8'd5; msr_in = ~v;
      int_pending = v[0]; int_id = v[3:1];
      if (v[4]) wr(v[7:5], v, "R7"); else rd(v[7:5], "R10");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule